// File: doc/BRIEF.md
# PCI Target Data-Phase Completion Status Generator

This block sits on the backend side of a 32-bit PCI target. For every data phase, it looks at the target's request handshake, the latched bus command, the address-claim comparator and the occupancy flags of a write FIFO and a read FIFO. From these it produces a 4-bit completion code. The target state machine reads that code to insert wait states, accept or supply a word, or end the transaction with a retry, a disconnect or a target abort. The block also drives the FIFO strobes. It pushes the write word together with its byte enables, and it pops the read FIFO while passing the popped word to the target.

The block treats the first beat of a request differently from the beats that follow. At the start of a transfer, a FIFO that is not ready gives a retry. Later in the transfer, the same condition gives a disconnect or a wait state. A loss of address claim is reported as a target abort only on later beats. The outputs are combinational in the current inputs and a single first-beat register. A code is therefore valid in the same cycle as the handshake it answers, and it takes effect on the next rising clock edge.

Top module: `tgtStatusGen`

## Requirements
- R1: The status codes are WAIT=0, TRANSFERED=1, DISCONNECT_WO_DATA=2, DISCONNECT_W_DATA=3, TABORT=4, MABORT=5 and RETRY=6. While request or ready is low, the status is WAIT and neither FIFO strobe is active. The code MABORT=5 never appears.
- R2: A read is a command with busCmd[0]=0. On the first beat of a read, an empty read FIFO (rfEmpty=1) gives RETRY with no pop.
- R3: A write is a command with busCmd[0]=1. On the first beat of a write, a full write FIFO gives RETRY with no push.
- R4: On a later beat of a write burst, a full write FIFO gives DISCONNECT_WO_DATA with no push.
- R5: On a write beat that is not the last, with the FIFO not full and wfAlmostFull=1, the status is DISCONNECT_W_DATA and the word is pushed. When that beat is the last (tLast=1), the status is TRANSFERED.
- R6: I/O commands have busCmd[3:1]=3'b001. On the first beat of an I/O access with tLast=0, the status is DISCONNECT_W_DATA and the word is moved. An I/O access with tLast=1 completes as TRANSFERED.
- R7: On a later beat with addrClaim=0, the status is TABORT with no strobe. On the first beat, addrClaim has no effect.
- R8: On a later beat of a read with the read FIFO empty, the status is WAIT with no pop. The burst then resumes as TRANSFERED once data is present.
- R9: A normal beat gives TRANSFERED. A write pushes wfPushWord = {byteEnN, wrData}. A read pops, and rdData equals rfData in that cycle. rdData is 0 whenever no pop happens.
- R10: The first-beat state is set while request is low. It is cleared by the first non-WAIT status of a request, and cycles with ready low leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tReq | input | 1 | Target has a request pending |
| tRdy | input | 1 | Target ready for the current data phase |
| tLast | input | 1 | Current data phase is the last of the request |
| busCmd | input | 4 | Latched PCI bus command |
| addrClaim | input | 1 | Current address lies in the claimed range |
| byteEnN | input | 4 | Active-low byte enables of the current phase |
| wrData | input | 32 | Write data of the current phase |
| wfFull | input | 1 | Write FIFO full |
| wfAlmostFull | input | 1 | Write FIFO has room for one word only |
| wfPush | output | 1 | Push strobe to the write FIFO |
| wfPushWord | output | 36 | Byte enables and data pushed |
| rfEmpty | input | 1 | Read FIFO empty |
| rfPop | output | 1 | Pop strobe to the read FIFO |
| rfData | input | 32 | Head word of the read FIFO |
| rdData | output | 32 | Read data handed to the target |
| phaseStatus | output | 4 | Completion code of the current phase |

## Verification
The bench targets the split between the first beat and later beats. A design that never clears the first-beat state would answer a full FIFO in mid-burst with RETRY instead of a disconnect. A design that clears it during ready-low cycles would disconnect a transfer that had not yet started. The bench also drives almost-full with last asserted, and a burst aimed at I/O space. A wrong priority in either case would shorten a legal single transfer, or it would let an I/O burst continue. Claim loss is applied both on the first beat and on a later beat, which catches a block that aborts unclaimed first beats. An empty read FIFO in mid-burst must give WAIT without a pop. A design that popped there would corrupt the data stream.

// File: rtl/tgtStatusPkg.sv
package tgtStatusPkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int CMD_W  = 4;

  typedef enum logic [3:0] {
    ST_WAIT    = 4'd0,
    ST_XFER    = 4'd1,
    ST_DISC_WO = 4'd2,
    ST_DISC_W  = 4'd3,
    ST_TABORT  = 4'd4,
    ST_MABORT  = 4'd5,
    ST_RETRY   = 4'd6
  } phaseStat_t;

  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrb_t;
endpackage

// File: rtl/tgtStatusCtrl.sv
module tgtStatusCtrl
  import tgtStatusPkg::*;
#(
  parameter int CMD_BITS = CMD_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tReq,
  input  logic                tRdy,
  input  logic                tLast,
  input  logic [CMD_BITS-1:0] busCmd,
  input  logic                addrClaim,
  input  logic                wfFull,
  input  logic                wfAlmostFull,
  input  logic                rfEmpty,
  output phaseStat_t          status,
  output fifoStrb_t           strb
);
  logic firstQ;
  logic isWr;
  logic isIo;
  logic moved;

  assign isWr = busCmd[0];
  assign isIo = (busCmd[CMD_BITS-1:1] == 3'b001);

  always_comb begin
    status = ST_WAIT;
    if (tReq && tRdy) begin
      if (!firstQ && !addrClaim) begin
        status = ST_TABORT;
      end else if (isWr) begin
        if (wfFull)
          status = firstQ ? ST_RETRY : ST_DISC_WO;
        else if (!tLast && ((firstQ && isIo) || wfAlmostFull))
          status = ST_DISC_W;
        else
          status = ST_XFER;
      end else begin
        if (rfEmpty)
          status = firstQ ? ST_RETRY : ST_WAIT;
        else if (!tLast && firstQ && isIo)
          status = ST_DISC_W;
        else
          status = ST_XFER;
      end
    end
  end

  assign moved     = (status == ST_XFER) || (status == ST_DISC_W);
  assign strb.push = moved && isWr;
  assign strb.pop  = moved && !isWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      firstQ <= 1'b1;
    else if (!tReq)
      firstQ <= 1'b1;
    else if (tRdy && status != ST_WAIT)
      firstQ <= 1'b0;
  end
endmodule

// File: rtl/tgtStatusDpath.sv
module tgtStatusDpath
  import tgtStatusPkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int BEW = BE_W
) (
  input  fifoStrb_t         strb,
  input  logic [BEW-1:0]    byteEnN,
  input  logic [DW-1:0]     wrData,
  input  logic [DW-1:0]     rfData,
  output logic [BEW+DW-1:0] pushWord,
  output logic [DW-1:0]     rdData
);
  assign pushWord = {byteEnN, wrData};
  assign rdData   = strb.pop ? rfData : '0;
endmodule

// File: rtl/tgtStatusGen.sv
module tgtStatusGen
  import tgtStatusPkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int BEW = DW / 8,
  parameter int CW  = CMD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tReq,
  input  logic              tRdy,
  input  logic              tLast,
  input  logic [CW-1:0]     busCmd,
  input  logic              addrClaim,
  input  logic [BEW-1:0]    byteEnN,
  input  logic [DW-1:0]     wrData,
  input  logic              wfFull,
  input  logic              wfAlmostFull,
  output logic              wfPush,
  output logic [BEW+DW-1:0] wfPushWord,
  input  logic              rfEmpty,
  output logic              rfPop,
  input  logic [DW-1:0]     rfData,
  output logic [DW-1:0]     rdData,
  output logic [3:0]        phaseStatus
);
  phaseStat_t stat;
  fifoStrb_t  strb;

  tgtStatusCtrl #(.CMD_BITS(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .tReq(tReq), .tRdy(tRdy), .tLast(tLast),
    .busCmd(busCmd), .addrClaim(addrClaim), .wfFull(wfFull),
    .wfAlmostFull(wfAlmostFull), .rfEmpty(rfEmpty),
    .status(stat), .strb(strb)
  );

  tgtStatusDpath #(.DW(DW), .BEW(BEW)) uDpath (
    .strb(strb), .byteEnN(byteEnN), .wrData(wrData), .rfData(rfData),
    .pushWord(wfPushWord), .rdData(rdData)
  );

  assign wfPush      = strb.push;
  assign rfPop       = strb.pop;
  assign phaseStatus = stat;
endmodule

// File: rtl/tgtStatusGenChk.sv
module tgtStatusGenChk (
  input logic       clk,
  input logic       rstN,
  input logic       tReq,
  input logic       tRdy,
  input logic [3:0] busCmd,
  input logic       addrClaim,
  input logic       wfFull,
  input logic       wfPush,
  input logic       rfEmpty,
  input logic       rfPop,
  input logic [3:0] phaseStatus
);
  a_r1_idle_wait: assert property (@(posedge clk) disable iff (!rstN)
    !(tReq && tRdy) |-> (phaseStatus == 4'd0 && !wfPush && !rfPop));

  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    (phaseStatus != 4'd5) && (phaseStatus <= 4'd6));

  a_r9_push_legal: assert property (@(posedge clk) disable iff (!rstN)
    wfPush |-> (busCmd[0] && (phaseStatus == 4'd1 || phaseStatus == 4'd3)));

  a_r9_pop_legal: assert property (@(posedge clk) disable iff (!rstN)
    rfPop |-> (!busCmd[0] && (phaseStatus == 4'd1 || phaseStatus == 4'd3)));

  a_r4_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    wfPush |-> !wfFull);

  a_r2_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    rfPop |-> !rfEmpty);

  a_r7_abort_unclaimed: assert property (@(posedge clk) disable iff (!rstN)
    (phaseStatus == 4'd4) |-> !addrClaim);

  a_r10_no_midburst_retry: assert property (@(posedge clk) disable iff (!rstN)
    (tReq && tRdy && phaseStatus != 4'd0) |=> (!tReq || phaseStatus != 4'd6));
endmodule

bind tgtStatusGen tgtStatusGenChk uChk (.*);

// File: tb/sim_tgtStatusGen.sv
module sim_tgtStatusGen;
  localparam logic [3:0] MEMW = 4'b0111, MEMR = 4'b0110, IOW = 4'b0011, IOR = 4'b0010;
  localparam logic [3:0] S_WAIT = 0, S_XFER = 1, S_DWO = 2, S_DW = 3, S_TAB = 4, S_RTY = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic tReq = 0, tRdy = 0, tLast = 0, addrClaim = 1;
  logic [3:0] busCmd = MEMW, byteEnN = 4'h0;
  logic [31:0] wrData = '0, rfData = '0;
  logic wfFull = 0, wfAlmostFull = 0, rfEmpty = 1;
  logic wfPush, rfPop;
  logic [35:0] wfPushWord;
  logic [31:0] rdData;
  logic [3:0] phaseStatus;

  int nChk = 0, nErr = 0;
  bit done = 0;

  typedef struct packed {
    logic [3:0]  st;
    logic        push;
    logic        pop;
    logic [35:0] word;
    logic [31:0] rd;
  } exp_t;
  exp_t expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  tgtStatusGen u0 (
    .clk(clk), .rstN(rstN), .tReq(tReq), .tRdy(tRdy), .tLast(tLast),
    .busCmd(busCmd), .addrClaim(addrClaim), .byteEnN(byteEnN), .wrData(wrData),
    .wfFull(wfFull), .wfAlmostFull(wfAlmostFull), .wfPush(wfPush),
    .wfPushWord(wfPushWord), .rfEmpty(rfEmpty), .rfPop(rfPop), .rfData(rfData),
    .rdData(rdData), .phaseStatus(phaseStatus)
  );

  // one call = one cycle of stimulus plus its expected result
  task automatic phase(input logic rq, input logic rd, input logic lst,
                       input logic [3:0] cmd, input logic clm,
                       input logic full, input logic af, input logic emp,
                       input logic [3:0] expSt, input string tag);
    exp_t e;
    @(negedge clk);
    tReq = rq; tRdy = rd; tLast = lst; busCmd = cmd; addrClaim = clm;
    wfFull = full; wfAlmostFull = af; rfEmpty = emp;
    wrData = wrData + 32'h1111_0001; byteEnN = byteEnN + 4'h3;
    rfData = rfData + 32'h0A0B_0C01;
    e.st   = expSt;
    e.push = cmd[0] && (expSt == S_XFER || expSt == S_DW);
    e.pop  = !cmd[0] && (expSt == S_XFER || expSt == S_DW);
    e.word = {byteEnN, wrData};
    e.rd   = e.pop ? rfData : 32'h0;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input string tag);
    phase(0, 0, 0, MEMW, 1, 0, 0, 1, S_WAIT, tag);
  endtask

  // monitor: compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        nChk++;
        if (phaseStatus !== e.st || wfPush !== e.push || rfPop !== e.pop ||
            (e.push && wfPushWord !== e.word) || rdData !== e.rd) begin
          nErr++;
          $display("FAIL %s: got st=%0d push=%0b pop=%0b word=%h rd=%h exp st=%0d push=%0b pop=%0b word=%h rd=%h",
                   t, phaseStatus, wfPush, rfPop, wfPushWord, rdData,
                   e.st, e.push, e.pop, e.word, e.rd);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

  initial begin
    idle("R1 reset state");
    idle("R1 reset state 2");
    @(negedge clk); rstN = 1'b1;
    // R1, R10: ready low holds wait; first beat survives it
    phase(1, 0, 0, MEMW, 1, 0, 0, 1, S_WAIT, "R1 rdy low wait");
    phase(1, 0, 0, MEMW, 1, 1, 0, 1, S_WAIT, "R10 rdy low keeps first");
    phase(1, 1, 0, MEMW, 1, 0, 0, 1, S_XFER, "R9 write first beat");
    phase(1, 0, 0, MEMW, 1, 1, 0, 1, S_WAIT, "R1 rdy low mid burst");
    phase(1, 1, 1, MEMW, 1, 0, 0, 1, S_XFER, "R9 write last beat");
    idle("R1 idle");
    // R3 full at start
    phase(1, 1, 0, MEMW, 1, 1, 0, 1, S_RTY, "R3 full first beat");
    idle("R10 req drop");
    // R4 full mid burst, after a ready-low gap (R10)
    phase(1, 1, 0, MEMW, 1, 0, 0, 1, S_XFER, "R4 setup");
    phase(1, 0, 0, MEMW, 1, 0, 0, 1, S_WAIT, "R10 gap");
    phase(1, 1, 0, MEMW, 1, 1, 0, 1, S_DWO, "R4 full later beat");
    idle("R10 rearm");
    phase(1, 1, 0, MEMW, 1, 1, 0, 1, S_RTY, "R10 first beat rearmed");
    idle("idle");
    // R5 almost full
    phase(1, 1, 0, MEMW, 1, 0, 1, 1, S_DW, "R5 almost full not last");
    idle("idle");
    phase(1, 1, 0, MEMW, 1, 0, 0, 1, S_XFER, "R5 setup");
    phase(1, 1, 1, MEMW, 1, 0, 1, 1, S_XFER, "R5 almost full last");
    idle("idle");
    // R6 I/O
    phase(1, 1, 0, IOW, 1, 0, 0, 1, S_DW, "R6 io write burst");
    idle("idle");
    phase(1, 1, 1, IOW, 1, 0, 0, 1, S_XFER, "R6 io write single");
    idle("idle");
    phase(1, 1, 0, IOR, 1, 0, 0, 0, S_DW, "R6 io read burst");
    idle("idle");
    // R7 claim
    phase(1, 1, 0, MEMW, 0, 0, 0, 1, S_XFER, "R7 claim ignored first");
    phase(1, 1, 0, MEMW, 0, 1, 0, 1, S_TAB, "R7 claim lost write");
    idle("idle");
    phase(1, 1, 0, MEMR, 1, 0, 0, 0, S_XFER, "R9 read first beat");
    phase(1, 1, 0, MEMR, 0, 0, 0, 0, S_TAB, "R7 claim lost read");
    idle("idle");
    // R2 read retry
    phase(1, 1, 0, MEMR, 1, 0, 0, 1, S_RTY, "R2 empty first read");
    idle("idle");
    // R8 read starve mid burst
    phase(1, 1, 0, MEMR, 1, 0, 0, 0, S_XFER, "R8 setup");
    phase(1, 1, 0, MEMR, 1, 0, 0, 1, S_WAIT, "R8 empty later beat");
    phase(1, 1, 0, MEMR, 1, 0, 0, 1, S_WAIT, "R8 still empty");
    phase(1, 1, 1, MEMR, 1, 0, 0, 0, S_XFER, "R8 resume");
    idle("R1 final idle");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule